// File: doc/BRIEF.md
# Eight-Level Masked Interrupt Arbiter

This block sits between a set of maskable interrupt sources and a CPU that keeps a 3-bit interrupt mask level. Each source has a pending flag, an enable bit and a 3-bit priority. A separate non-maskable source also feeds the block. Every cycle the arbiter picks the most urgent enabled pending request. It then decides whether the CPU may take that request now: the request's priority must be strictly above the mask level, and the CPU must sit at an instruction boundary.

When a request is accepted, the block presents several outputs. These are a vector number for the vector-table lookup, the mask level the CPU must load and a strobe that clears the trace bit. The CPU confirms that it has taken the interrupt by raising an acknowledge in a cycle where the accept is high. This clears the pending flag of the source that won. Pending requests that lose arbitration, or that are held back by the mask, are kept until they are served or cleared by software.

Top module: `irq_level_arb`

## Requirements
- R1: A one-cycle pulse on `src_raise_i[k]` sets the pending flag of source k. The flag stays set until `src_clr_i[k]` is pulsed or the CPU acknowledges an accept of source k.
- R2: A source with `src_en_i[k]=0` takes no part in arbitration. Its pending flag is kept, so it competes again as soon as the enable returns, with no new raise.
- R3: Among enabled pending sources, the one with the numerically greatest priority in `src_prio_i[3k+2:3k]` wins.
- R4: When several winners share the greatest priority, the lowest source index wins.
- R5: A maskable winner is accepted only if its priority is strictly greater than `mask_lvl_i`. If the priority is equal to or below the mask level, nothing is accepted and the request stays pending.
- R6: A pending non-maskable request beats every maskable one and is accepted whatever the mask level. It is reported with `is_nmi_o=1`, vector 0 and new mask level 7.
- R7: `accept_o` is 0 whenever `boundary_i` is 0.
- R8: An accepted maskable source k is reported with vector number k+1 on `vec_o` and `is_nmi_o=0`.
- R9: While `accept_o` is 1, `new_mask_o` carries the accepted priority (7 for the non-maskable request), and `trace_clr_o` is high exactly when `accept_o` is high.
- R10: `ack_i` high together with `accept_o` clears only the winner's pending flag. Every other pending flag, including the non-maskable one, is kept.
- R11: After reset no flag is pending and `accept_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_raise_i | input | N_SRC | Per-source request pulse, sets pending |
| src_clr_i | input | N_SRC | Per-source software clear of pending |
| src_en_i | input | N_SRC | Per-source enable |
| src_prio_i | input | 3*N_SRC | Packed 3-bit priority per source, source k at bits 3k+2:3k |
| nmi_raise_i | input | 1 | Non-maskable request pulse |
| mask_lvl_i | input | 3 | CPU's current interrupt mask level |
| boundary_i | input | 1 | CPU is at an instruction boundary |
| ack_i | input | 1 | CPU takes the accepted interrupt |
| accept_o | output | 1 | Interrupt accepted this cycle |
| is_nmi_o | output | 1 | Accepted interrupt is non-maskable |
| vec_o | output | $clog2(N_SRC+1) | Vector number of the accepted source |
| new_mask_o | output | 3 | Mask level for the CPU to load on accept |
| trace_clr_o | output | 1 | Clear the trace bit |

## Verification
The hardest situation to reach is one where a masked or disabled request must survive while other events happen around it. Examples are a tie being served and acknowledged, a non-maskable request overtaking it, or its enable being toggled. The bench builds these states from a cleared starting point with raise pulses. It then walks the acknowledge one source at a time and checks that the next winner is exactly the one predicted for the remaining flags. A sweep covers every source, priority and mask level one at a time. A pseudo-random phase then mixes the enables, priorities and multi-source pending patterns against a bench-side priority model.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned PRIO_W = 3;
  localparam logic [PRIO_W-1:0] LVL_TOP = '1;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  // set beats clear so a fresh event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_arb_pkg::*;
#(
  parameter int unsigned N     = 8,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]             req_i,
  input  logic [N-1:0][PRIO_W-1:0] prio_i,
  output logic                     valid_o,
  output logic [IDX_W-1:0]         idx_o,
  output logic [PRIO_W-1:0]        prio_o
);
  // scan high to low index; >= lets lower index take ties
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i] && (!valid_o || prio_i[i] >= prio_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
  import irq_arb_pkg::*;
#(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned VEC_W = 4
) (
  input  logic              cand_vld_i,
  input  logic [IDX_W-1:0]  cand_idx_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic              nmi_pend_i,
  input  logic [PRIO_W-1:0] mask_lvl_i,
  input  logic              boundary_i,
  output logic              accept_o,
  output logic              is_nmi_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [PRIO_W-1:0] new_mask_o
);
  logic mask_ok;

  assign mask_ok  = cand_vld_i && (cand_prio_i > mask_lvl_i);
  assign is_nmi_o = nmi_pend_i;
  assign accept_o = boundary_i && (nmi_pend_i || mask_ok);

  always_comb begin
    if (nmi_pend_i) begin
      vec_o      = '0;
      new_mask_o = LVL_TOP;
    end else begin
      vec_o      = VEC_W'(cand_idx_i) + VEC_W'(1);
      new_mask_o = cand_prio_i;
    end
  end
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb
  import irq_arb_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int unsigned VEC_W = $clog2(N_SRC + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_SRC-1:0]         src_raise_i,
  input  logic [N_SRC-1:0]         src_clr_i,
  input  logic [N_SRC-1:0]         src_en_i,
  input  logic [N_SRC*PRIO_W-1:0]  src_prio_i,
  input  logic                     nmi_raise_i,
  input  logic [PRIO_W-1:0]        mask_lvl_i,
  input  logic                     boundary_i,
  input  logic                     ack_i,
  output logic                     accept_o,
  output logic                     is_nmi_o,
  output logic [VEC_W-1:0]         vec_o,
  output logic [PRIO_W-1:0]        new_mask_o,
  output logic                     trace_clr_o
);
  logic [N_SRC-1:0]             pend_q;
  logic [N_SRC-1:0]             src_ack;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_arr;
  logic                         nmi_pend_q;
  logic                         nmi_ack;
  logic                         cand_vld;
  logic [IDX_W-1:0]             cand_idx;
  logic [PRIO_W-1:0]            cand_prio;
  logic                         taken;

  for (genvar g = 0; g < N_SRC; g++) begin : g_unpack
    assign prio_arr[g] = src_prio_i[g*PRIO_W +: PRIO_W];
  end

  assign taken   = accept_o && ack_i;
  assign nmi_ack = taken && is_nmi_o;

  always_comb begin
    src_ack = '0;
    if (taken && !is_nmi_o) src_ack[cand_idx] = 1'b1;
  end

  irq_pend_bank #(.N(N_SRC)) src_bank_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (src_raise_i),
    .clr_i  (src_clr_i | src_ack),
    .pend_o (pend_q)
  );

  irq_pend_bank #(.N(1)) nmi_bank_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (nmi_raise_i),
    .clr_i  (nmi_ack),
    .pend_o (nmi_pend_q)
  );

  irq_prio_pick #(.N(N_SRC)) pick_i (
    .req_i   (pend_q & src_en_i),
    .prio_i  (prio_arr),
    .valid_o (cand_vld),
    .idx_o   (cand_idx),
    .prio_o  (cand_prio)
  );

  irq_accept_gate #(.IDX_W(IDX_W), .VEC_W(VEC_W)) gate_i (
    .cand_vld_i  (cand_vld),
    .cand_idx_i  (cand_idx),
    .cand_prio_i (cand_prio),
    .nmi_pend_i  (nmi_pend_q),
    .mask_lvl_i  (mask_lvl_i),
    .boundary_i  (boundary_i),
    .accept_o    (accept_o),
    .is_nmi_o    (is_nmi_o),
    .vec_o       (vec_o),
    .new_mask_o  (new_mask_o)
  );

  assign trace_clr_o = accept_o;
endmodule

// File: rtl/irq_level_arb_chk.sv
module irq_level_arb_chk #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned VEC_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] src_raise_i,
  input logic [N_SRC-1:0] pend_q,
  input logic             nmi_pend_q,
  input logic [2:0]       mask_lvl_i,
  input logic             boundary_i,
  input logic             accept_o,
  input logic             is_nmi_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [2:0]       new_mask_o,
  input logic             trace_clr_o
);
  assert_raise_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_raise_i) |=> (|pend_q));

  assert_strict_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && !is_nmi_o) |-> (new_mask_o > mask_lvl_i));

  assert_nmi_always_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_pend_q && boundary_i) |-> (accept_o && is_nmi_o && vec_o == '0 && new_mask_o == 3'd7));

  assert_boundary_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_i |-> !accept_o);

  assert_maskable_vec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && !is_nmi_o) |-> (vec_o != '0));

  assert_trace_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trace_clr_o == accept_o);
endmodule

bind irq_level_arb irq_level_arb_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_raise_i (src_raise_i),
  .pend_q      (pend_q),
  .nmi_pend_q  (nmi_pend_q),
  .mask_lvl_i  (mask_lvl_i),
  .boundary_i  (boundary_i),
  .accept_o    (accept_o),
  .is_nmi_o    (is_nmi_o),
  .vec_o       (vec_o),
  .new_mask_o  (new_mask_o),
  .trace_clr_o (trace_clr_o)
);

// File: tb/irq_level_arb_tb_top.sv
module irq_level_arb_tb_top;
  localparam int N = 8;
  localparam int VW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  raise = '0, sclr = '0, en = '0;
  logic [3*N-1:0] prio = '0;
  logic          nmi = 1'b0, bnd = 1'b0, ack = 1'b0;
  logic [2:0]    mask = '0;
  logic          acc, isn, tclr;
  logic [VW-1:0] vec;
  logic [2:0]    nmask;

  int checks = 0, errors = 0;
  logic [31:0] lfsr = 32'hACE1_2024;

  always #5 clk = ~clk;

  irq_level_arb #(.N_SRC(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_raise_i(raise), .src_clr_i(sclr),
    .src_en_i(en), .src_prio_i(prio), .nmi_raise_i(nmi), .mask_lvl_i(mask),
    .boundary_i(bnd), .ack_i(ack), .accept_o(acc), .is_nmi_o(isn),
    .vec_o(vec), .new_mask_o(nmask), .trace_clr_o(tclr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_raise(input logic [N-1:0] m);
    @(negedge clk); raise = m;
    @(negedge clk); raise = '0; #1;
  endtask

  task automatic pulse_nmi();
    @(negedge clk); nmi = 1'b1;
    @(negedge clk); nmi = 1'b0; #1;
  endtask

  task automatic clr_all();
    @(negedge clk); sclr = '1;
    @(negedge clk); sclr = '0; #1;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0; #1;
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic int prio_of(input int k);
    return int'(prio[3*k +: 3]);
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    bnd = 1'b1; en = '1;
    #1;
    chk("R11 accept after reset", int'(acc), 0);
    chk("R11 trace after reset", int'(tclr), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R11 accept idle", int'(acc), 0);

    // R5 R8 R9 sweep: every source, priority, mask level
    for (int k = 0; k < N; k++) begin
      for (int p = 0; p < 8; p++) begin
        prio = '0; prio[3*k +: 3] = 3'(p);
        pulse_raise(N'(1) << k);
        for (int m = 0; m < 8; m++) begin
          mask = 3'(m); #1;
          chk("R5 strict mask", int'(acc), (p > m) ? 1 : 0);
          chk("R9 trace strobe", int'(tclr), (p > m) ? 1 : 0);
          if (p > m) begin
            chk("R8 vector", int'(vec), k + 1);
            chk("R8 not nmi", int'(isn), 0);
            chk("R9 new mask", int'(nmask), p);
          end
        end
        clr_all();
        chk("R1 sw clear", int'(acc), 0);
      end
    end

    // R7 boundary gating
    mask = 3'd0; prio = '1;
    pulse_raise(8'h10);
    bnd = 1'b0; #1;
    chk("R7 no boundary", int'(acc), 0);
    bnd = 1'b1; #1;
    chk("R7 boundary", int'(acc), 1);

    // R2 disable keeps pending
    en[4] = 1'b0; #1;
    chk("R2 disabled", int'(acc), 0);
    repeat (3) @(negedge clk);
    en[4] = 1'b1; #1;
    chk("R2 re-enabled", int'(acc), 1);
    chk("R2 vector", int'(vec), 5);
    clr_all();

    // R4 ties walked by R10 acks
    prio = '0;
    for (int k = 0; k < N; k++) prio[3*k +: 3] = 3'd5;
    mask = 3'd2;
    pulse_raise(8'b1010_0110);
    chk("R4 tie lowest", int'(vec), 2);
    do_ack();
    chk("R10 next tie", int'(vec), 3);
    do_ack();
    chk("R10 next tie", int'(vec), 6);
    do_ack();
    chk("R10 next tie", int'(vec), 8);
    do_ack();
    chk("R10 all served", int'(acc), 0);

    // R6 nmi overrides mask 7 and maskable prio 7
    prio[3*3 +: 3] = 3'd7; mask = 3'd7;
    pulse_raise(8'h08);
    chk("R5 equal prio held", int'(acc), 0);
    pulse_nmi();
    chk("R6 nmi accept", int'(acc), 1);
    chk("R6 nmi flag", int'(isn), 1);
    chk("R6 nmi vector", int'(vec), 0);
    chk("R6 nmi mask", int'(nmask), 7);
    do_ack();
    chk("R10 nmi cleared", int'(isn), 0);
    mask = 3'd6; #1;
    chk("R10 maskable kept", int'(vec), 4);
    chk("R10 maskable accept", int'(acc), 1);
    clr_all();

    // R3 random mixes against a priority model
    for (int it = 0; it < 400; it++) begin
      logic [N-1:0] pm;
      int best, bidx;
      lfsr = nxt(lfsr); en = lfsr[7:0];
      lfsr = nxt(lfsr); prio[15:0] = lfsr[15:0];
      lfsr = nxt(lfsr); prio[23:16] = lfsr[7:0];
      lfsr = nxt(lfsr); mask = lfsr[2:0]; pm = lfsr[15:8];
      pulse_raise(pm);
      best = -1; bidx = 0;
      for (int k = 0; k < N; k++)
        if (pm[k] && en[k] && prio_of(k) > best) begin best = prio_of(k); bidx = k; end
      chk("R3 accept", int'(acc), (best > int'(mask)) ? 1 : 0);
      if (best > int'(mask)) begin
        chk("R3 winner", int'(vec), bidx + 1);
        chk("R3 new mask", int'(nmask), best);
      end
      clr_all();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule